// File: doc/BRIEF.md
# DMA Channel Suspend and Disable Controller

This block is one DMA channel. It moves bytes from a source handshake port to a destination handshake port through a 16-byte channel FIFO. Source beats may be narrower than destination words. The FIFO packs them little-endian, so the oldest byte lands in the lowest byte lane. Control comes in as one-cycle pulses: enable, disable request, suspend and resume. A level input acts as a global enable. Status comes back as three levels: channel enabled, suspended, and FIFO empty.

Disabling is graceful. A disable request, or the global enable going low, is held pending for one cycle. During that cycle both handshakes are refused, and any beat in flight is abandoned. At the following edge the channel drops its enabled status and discards whatever bytes the FIFO still holds.

Suspend stops intake from the source while the destination keeps draining. "Empty" means the FIFO cannot form one destination word, which is not the same as holding zero bytes. Either side can be named the flow controller. The other side is then not serviced until that controller has signalled its last transfer.

Top module: `dma_chan_top`

## Requirements
- R1: Width codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. When `dstAck` is high, byte lane k of `dstData` carries the k-th oldest FIFO byte for every k below the destination width in bytes. Higher lanes read zero. Source beats enter the FIFO lowest lane first.
- R2: After a disable request on an enabled channel with no request already pending, `chEnabled` reads 1 for exactly one more cycle and then 0.
- R3: While `suspended` is 1, `srcAck` stays 0 and the destination side is still served.
- R4: `fifoEmpty` is 1 exactly when the FIFO holds fewer bytes than one destination word, including while bytes remain.
- R5: A resume pulse clears `suspended`, and transfers then carry on with the stored data intact.
- R6: A low `globalEnable` acts as a disable request on an enabled channel. An enable pulse is ignored while `globalEnable` is low.
- R7: Bytes left in the FIFO when the channel disables are dropped. After re-enable, the first destination word contains only newly received bytes.
- R8: The flow-controller code is 2'b10 for destination and 2'b01 for source; 2'b00 and 2'b11 mean no gating. With 2'b10, `srcAck` stays 0 until `dstLast` has been seen high while the channel is enabled. With 2'b01, `dstAck` stays 0 until `srcLast` has been seen. A new enable re-arms the gate.
- R9: A configuration write takes effect only while `chEnabled` is 0. A write while enabled leaves widths and flow selection unchanged.
- R10: In the cycle a disable is pending, both `srcAck` and `dstAck` are 0.
- R11: A resume pulse while not suspended changes nothing. A suspend pulse while disabled changes nothing.
- R12: `srcAck` is given only when the stored byte count plus the source width in bytes is at most 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| globalEnable | input | 1 | Global enable level; low requests disable |
| chEnableSet | input | 1 | Pulse: enable the channel |
| chDisableReq | input | 1 | Pulse: request channel disable |
| suspendSet | input | 1 | Pulse: suspend source intake |
| resumeSet | input | 1 | Pulse: leave suspension |
| cfgWrite | input | 1 | Pulse: load the configuration fields |
| cfgSrcWidth | input | 2 | Source beat width code |
| cfgDstWidth | input | 2 | Destination word width code |
| cfgFlow | input | 2 | Flow-controller selection |
| srcReq | input | 1 | Source offers a single beat |
| srcData | input | 32 | Source beat data, low lanes used |
| srcLast | input | 1 | Source signals its last transfer |
| srcAck | output | 1 | Source beat accepted this cycle |
| dstReq | input | 1 | Destination asks for a single word |
| dstLast | input | 1 | Destination signals its last transfer |
| dstAck | output | 1 | Destination word delivered this cycle |
| dstData | output | 32 | Destination word, valid with dstAck |
| chEnabled | output | 1 | Channel enabled status |
| suspended | output | 1 | Channel suspended status |
| fifoEmpty | output | 1 | FIFO cannot form one destination word |

## Verification
Every cycle, the embedded assertions check several properties. The FIFO never overflows or pops more than it holds. A push always fits the free space. The disable latency is exactly one cycle. A flush leaves a zero count. Configuration stays stable while enabled. Suspension cannot arise from nothing.

Other behaviours show up only in the bench's directed scenarios, compared cycle by cycle against a queue model. These include the little-endian lane order, residue being gone after re-enable, and the flow-controller gates opening only after the matching last signal. They also include a suspended channel draining down to a partial word with the empty flag raised.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    FLOW_NONE = 2'b00,
    FLOW_SRC  = 2'b01,
    FLOW_DST  = 2'b10,
    FLOW_ALT  = 2'b11
  } flowSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       flush;
    logic [2:0] pushBytes;
    logic [2:0] popBytes;
  } dpStrobe_t;

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (code)
      2'd0:    widthBytes = 3'd1;
      2'd1:    widthBytes = 3'd2;
      default: widthBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_fifo.sv
module dma_chan_fifo
  import dma_chan_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BUS_BYTES = 4,
  parameter int LW        = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic [8*BUS_BYTES-1:0] srcData,
  output logic [8*BUS_BYTES-1:0] dstData,
  output logic [LW-1:0]          level
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [LW-1:0] levelQ;
  logic [LW-1:0] addAmt, subAmt;

  assign addAmt = stb.push ? LW'(stb.pushBytes) : '0;
  assign subAmt = stb.pop  ? LW'(stb.popBytes)  : '0;
  assign level  = levelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      levelQ <= '0;
    end else if (stb.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      levelQ <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + PW'(stb.pushBytes);
      if (stb.pop)  rdPtr <= rdPtr + PW'(stb.popBytes);
      levelQ <= levelQ + addAmt - subAmt;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (stb.push && !stb.flush && (k < int'(stb.pushBytes)))
        mem[wrPtr + PW'(k)] <= srcData[8*k +: 8];
    end
  end

  generate
    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
      assign dstData[8*g +: 8] = (g < int'(stb.popBytes)) ? mem[rdPtr + PW'(g)] : 8'h00;
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(levelQ) <= DEPTH); // R12
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (int'(levelQ) + int'(stb.pushBytes) <= DEPTH)); // R12
  AST_POP_HAS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (int'(levelQ) >= int'(stb.popBytes))); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (levelQ == '0)); // R7

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          globalEnable,
  input  logic          chEnableSet,
  input  logic          chDisableReq,
  input  logic          suspendSet,
  input  logic          resumeSet,
  input  logic          cfgWrite,
  input  logic [1:0]    cfgSrcWidth,
  input  logic [1:0]    cfgDstWidth,
  input  logic [1:0]    cfgFlow,
  input  logic          srcReq,
  input  logic          srcLast,
  input  logic          dstReq,
  input  logic          dstLast,
  input  logic [LW-1:0] level,
  output logic          srcAck,
  output logic          dstAck,
  output logic          chEnabled,
  output logic          suspended,
  output logic          fifoEmpty,
  output dpStrobe_t     stb
);
  logic       enabledQ, pendQ, suspQ, lastSeenQ;
  logic [1:0] srcWQ, dstWQ;
  flowSel_e   flowQ;
  logic [2:0] srcBytes, dstBytes;
  logic       live, roomOk, wordOk, gateSrc, gateDst, stopReq;

  assign srcBytes = widthBytes(srcWQ);
  assign dstBytes = widthBytes(dstWQ);
  assign live     = enabledQ && !pendQ;
  assign roomOk   = (int'(level) + int'(srcBytes)) <= DEPTH;
  assign wordOk   = int'(level) >= int'(dstBytes);
  assign gateSrc  = (flowQ == FLOW_DST) && !lastSeenQ;
  assign gateDst  = (flowQ == FLOW_SRC) && !lastSeenQ;
  assign stopReq  = chDisableReq || !globalEnable;

  assign srcAck = srcReq && live && !suspQ && roomOk && !gateSrc;
  assign dstAck = dstReq && live && wordOk && !gateDst;

  assign chEnabled = enabledQ;
  assign suspended = suspQ;
  assign fifoEmpty = !wordOk;

  always_comb begin
    stb           = '0;
    stb.push      = srcAck;
    stb.pop       = dstAck;
    stb.flush     = enabledQ && pendQ;
    stb.pushBytes = srcBytes;
    stb.popBytes  = dstBytes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabledQ  <= 1'b0;
      pendQ     <= 1'b0;
      suspQ     <= 1'b0;
      lastSeenQ <= 1'b0;
      srcWQ     <= 2'd0;
      dstWQ     <= 2'd0;
      flowQ     <= FLOW_NONE;
    end else if (!enabledQ) begin
      pendQ     <= 1'b0;
      suspQ     <= 1'b0;
      lastSeenQ <= 1'b0;
      if (cfgWrite) begin
        srcWQ <= cfgSrcWidth;
        dstWQ <= cfgDstWidth;
        flowQ <= flowSel_e'(cfgFlow);
      end
      if (chEnableSet && globalEnable) enabledQ <= 1'b1;
    end else if (pendQ) begin
      enabledQ <= 1'b0;
      pendQ    <= 1'b0;
      suspQ    <= 1'b0;
    end else begin
      if (stopReq) pendQ <= 1'b1;
      if (suspendSet)     suspQ <= 1'b1;
      else if (resumeSet) suspQ <= 1'b0;
      if ((flowQ == FLOW_DST && dstLast) || (flowQ == FLOW_SRC && srcLast))
        lastSeenQ <= 1'b1;
    end
  end

  AST_DISABLE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (enabledQ && !pendQ && stopReq) |=> (enabledQ ##1 !enabledQ)); // R2
  AST_PENDING_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (enabledQ && !pendQ && stopReq) |=> (!srcAck && !dstAck)); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    enabledQ |=> ($stable(srcWQ) && $stable(dstWQ) && $stable(flowQ))); // R9
  AST_SUSP_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!suspQ && !suspendSet) |=> !suspQ); // R11
  AST_IDLE_NOT_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    !enabledQ |=> !suspQ); // R11
  AST_GLOBAL_BLOCKS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enabledQ && !globalEnable) |=> !enabledQ); // R6

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   globalEnable,
  input  logic                   chEnableSet,
  input  logic                   chDisableReq,
  input  logic                   suspendSet,
  input  logic                   resumeSet,
  input  logic                   cfgWrite,
  input  logic [1:0]             cfgSrcWidth,
  input  logic [1:0]             cfgDstWidth,
  input  logic [1:0]             cfgFlow,
  input  logic                   srcReq,
  input  logic [8*BUS_BYTES-1:0] srcData,
  input  logic                   srcLast,
  output logic                   srcAck,
  input  logic                   dstReq,
  input  logic                   dstLast,
  output logic                   dstAck,
  output logic [8*BUS_BYTES-1:0] dstData,
  output logic                   chEnabled,
  output logic                   suspended,
  output logic                   fifoEmpty
);
  localparam int LW = $clog2(DEPTH + 1);

  dpStrobe_t     stb;
  logic [LW-1:0] level;

  dma_chan_ctrl #(.DEPTH(DEPTH), .LW(LW)) ctrl_i (
    .clk(clk), .rstN(rstN), .globalEnable(globalEnable),
    .chEnableSet(chEnableSet), .chDisableReq(chDisableReq),
    .suspendSet(suspendSet), .resumeSet(resumeSet), .cfgWrite(cfgWrite),
    .cfgSrcWidth(cfgSrcWidth), .cfgDstWidth(cfgDstWidth), .cfgFlow(cfgFlow),
    .srcReq(srcReq), .srcLast(srcLast), .dstReq(dstReq), .dstLast(dstLast),
    .level(level), .srcAck(srcAck), .dstAck(dstAck), .chEnabled(chEnabled),
    .suspended(suspended), .fifoEmpty(fifoEmpty), .stb(stb)
  );

  dma_chan_fifo #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES), .LW(LW)) fifo_i (
    .clk(clk), .rstN(rstN), .stb(stb), .srcData(srcData),
    .dstData(dstData), .level(level)
  );

endmodule

// File: tb/dma_chan_top_tb.sv
module dma_chan_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEnable = 1'b1, chEnableSet = 0, chDisableReq = 0, suspendSet = 0, resumeSet = 0;
  logic cfgWrite = 0;
  logic [1:0] cfgSrcWidth = 0, cfgDstWidth = 0, cfgFlow = 0;
  logic srcReq = 0, srcLast = 0, dstReq = 0, dstLast = 0;
  logic [31:0] srcData = 0;
  logic srcAck, dstAck, chEnabled, suspended, fifoEmpty;
  logic [31:0] dstData;

  always #2.5 clk = ~clk;

  dma_chan_top dut_i (
    .clk(clk), .rstN(rstN), .globalEnable(globalEnable), .chEnableSet(chEnableSet),
    .chDisableReq(chDisableReq), .suspendSet(suspendSet), .resumeSet(resumeSet),
    .cfgWrite(cfgWrite), .cfgSrcWidth(cfgSrcWidth), .cfgDstWidth(cfgDstWidth),
    .cfgFlow(cfgFlow), .srcReq(srcReq), .srcData(srcData), .srcLast(srcLast),
    .srcAck(srcAck), .dstReq(dstReq), .dstLast(dstLast), .dstAck(dstAck),
    .dstData(dstData), .chEnabled(chEnabled), .suspended(suspended), .fifoEmpty(fifoEmpty)
  );

  // reference model state
  bit mEn, mPend, mSusp, mLast;
  int mS, mD, mF;
  byte unsigned q[$];
  int vectors = 0, miss = 0;
  bit done = 0;
  string phase = "reset";

  function automatic int wb(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miss++;
      $display("FAIL %s in phase %s: actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  // called at a falling edge with inputs set; returns at the next falling edge
  task automatic cyc();
    int sb, db;
    bit eS, eD;
    logic [31:0] eData;
    #1;
    sb = wb(mS);
    db = wb(mD);
    eS = srcReq && mEn && !mPend && !mSusp && (q.size() + sb <= 16) && !(mF == 2 && !mLast);
    eD = dstReq && mEn && !mPend && (q.size() >= db) && !(mF == 1 && !mLast);
    eData = 0;
    if (eD) for (int k = 0; k < db; k++) eData[8*k +: 8] = q[k];
    vectors++;
    chk("R12/R3 srcAck", {31'd0, srcAck}, {31'd0, eS});
    chk("R8/R10 dstAck", {31'd0, dstAck}, {31'd0, eD});
    chk("R2 chEnabled", {31'd0, chEnabled}, {31'd0, mEn});
    chk("R5 suspended", {31'd0, suspended}, {31'd0, mSusp});
    chk("R4 fifoEmpty", {31'd0, fifoEmpty}, {31'd0, (q.size() < db)});
    if (eD) chk("R1 dstData", dstData, eData);
    if (eD) for (int k = 0; k < db; k++) void'(q.pop_front());
    if (eS) for (int k = 0; k < sb; k++) q.push_back(srcData[8*k +: 8]);
    if (!mEn) begin
      mPend = 0; mSusp = 0; mLast = 0;
      if (cfgWrite) begin mS = cfgSrcWidth; mD = cfgDstWidth; mF = cfgFlow; end
      if (chEnableSet && globalEnable) mEn = 1;
    end else if (mPend) begin
      mEn = 0; mPend = 0; mSusp = 0;
      q.delete();
    end else begin
      if (chDisableReq || !globalEnable) mPend = 1;
      if (suspendSet) mSusp = 1;
      else if (resumeSet) mSusp = 0;
      if ((mF == 2 && dstLast) || (mF == 1 && srcLast)) mLast = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rnd(int n, int lastPct);
    for (int i = 0; i < n; i++) begin
      srcReq  = ($urandom % 2) == 0;
      dstReq  = ($urandom % 2) == 0;
      srcData = $urandom;
      srcLast = ($urandom % 100) < lastPct;
      dstLast = ($urandom % 100) < lastPct;
      cyc();
    end
    srcReq = 0; dstReq = 0; srcLast = 0; dstLast = 0;
  endtask

  task automatic configure(int s, int d, int f, bit en);
    cfgWrite = 1; cfgSrcWidth = 2'(s); cfgDstWidth = 2'(d); cfgFlow = 2'(f);
    chEnableSet = en;
    cyc();
    cfgWrite = 0; chEnableSet = 0;
  endtask

  task automatic pulseDisable();
    chDisableReq = 1; cyc(); chDisableReq = 0; idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "reset";
    idle(2);

    phase = "R9 idle config";
    configure(0, 2, 0, 1);
    phase = "R1 pack 8 to 32";
    rnd(60, 0);
    phase = "R9 write while enabled";
    configure(2, 0, 1, 0);
    rnd(20, 0);

    phase = "R3 R4 suspend drain";
    srcReq = 1; srcData = 32'h11223344;
    cyc();
    suspendSet = 1; cyc(); suspendSet = 0;
    dstReq = 1;
    for (int i = 0; i < 12; i++) begin srcData = $urandom; cyc(); end
    dstReq = 0; srcReq = 0;

    phase = "R5 resume";
    resumeSet = 1; cyc(); resumeSet = 0;
    rnd(30, 0);
    phase = "R11 stray resume";
    resumeSet = 1; cyc(); resumeSet = 0;
    rnd(10, 0);

    phase = "R10 R2 R7 disable with residue";
    srcReq = 1;
    for (int i = 0; i < 3; i++) begin srcData = $urandom; cyc(); end
    dstReq = 1; chDisableReq = 1; cyc(); chDisableReq = 0;
    idle(4);
    srcReq = 0; dstReq = 0;

    phase = "R11 suspend while disabled";
    suspendSet = 1; cyc(); suspendSet = 0;
    idle(2);

    phase = "R7 reenable new data";
    configure(1, 1, 0, 1);
    rnd(40, 0);

    phase = "R6 global low";
    globalEnable = 0; idle(4);
    chEnableSet = 1; cyc(); chEnableSet = 0;
    idle(2);
    globalEnable = 1;
    chEnableSet = 1; cyc(); chEnableSet = 0;
    rnd(10, 0);
    pulseDisable();

    phase = "R8 dest flow control";
    configure(0, 1, 2, 1);
    srcReq = 1; dstReq = 1; idle(10);
    dstLast = 1; cyc(); dstLast = 0;
    rnd(20, 0);
    pulseDisable();

    phase = "R8 source flow control R12";
    configure(2, 0, 1, 1);
    srcReq = 1; dstReq = 1;
    for (int i = 0; i < 8; i++) begin srcData = $urandom; cyc(); end
    srcLast = 1; cyc(); srcLast = 0;
    rnd(20, 0);
    pulseDisable();

    phase = "R12 full fifo";
    configure(2, 2, 0, 1);
    srcReq = 1;
    for (int i = 0; i < 8; i++) begin srcData = $urandom; cyc(); end
    srcReq = 0;
    pulseDisable();

    phase = "mixed R1 R3 R5 R8";
    for (int r = 0; r < 40; r++) begin
      if (!mEn) configure($urandom % 4, $urandom % 4, $urandom % 4, 1);
      suspendSet = ($urandom % 8) == 0;
      resumeSet  = ($urandom % 4) == 0;
      chDisableReq = ($urandom % 20) == 0;
      rnd(1, 0);
      suspendSet = 0; resumeSet = 0; chDisableReq = 0;
      rnd(20, 5);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired in phase %s: actual=running expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

endmodule